// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

The engine follows a chain of three-word descriptors kept in memory. Software supplies the address of the first descriptor and pulses a start input. The engine reads a descriptor through a descriptor read port and copies the byte count it names. The copy goes from the source address to the destination address over a data memory port, one 32-bit word at a time, as a read followed by a write. It then moves to the descriptor twelve bytes further on. The walk ends in one of four ways: a descriptor carrying the last flag completes, a descriptor is malformed, a port reports an error, or a bounded number of descriptors has been walked without a last flag.

Each walk is started with a direction type: read type or write type. The type decides which completion bit and which transfer-error bit the walk reports. The outcome goes into a five-bit status register whose bits stay set until software writes ones to them. A one-cycle done interrupt fires only when a descriptor with the last flag finishes.

Both memory ports follow the same request rules. A request is held with valid until the cycle in which ready is high. Address, write flag, write data and byte enables stay constant while valid is high and ready is low. Only one request is ever outstanding across both ports. A new request is issued only after the response to the previous one has arrived. Responses carry no ready, because the engine always accepts them.

Top module: `sg_dma_engine`

## Requirements
- R1: Descriptor words are fetched in the order base, base+4, base+8, holding source, destination and control. The following descriptor starts at base+12. No fetch happens before start.
- R2: Control word layout: bits 17:0 give the byte count, bit 31 is the last flag, and bits 30:18 are reserved and must be zero.
- R3: For a count of N bytes, the engine reads word k from source+4k and writes the same data to destination+4k, with k rising from 0 to ceil(N/4)-1.
- R4: Data is little-endian: byte-enable bit n covers the byte at address+n. Every word except the final one of a descriptor has all four enables set. The final word enables only the low (N mod 4) lanes when N mod 4 is not zero.
- R5: When a descriptor with the last flag completes, irq_o is high for exactly one cycle. At the same clock edge busy_o falls and status bit 0 (read type) or bit 1 (write type) is set. No other outcome ever raises irq_o.
- R6: A descriptor with a zero count sets status bit 4, issues no data request and ends the walk. So does a descriptor with any reserved bit set.
- R7: If MAX_DESC descriptors complete without a last flag, status bit 4 is set and the walk ends with no further fetch.
- R8: An error response on the data port ends the walk with no further request. It sets status bit 2 for a read-type walk and bit 3 for a write-type walk.
- R9: An error response on the descriptor port sets status bit 4 and ends the walk.
- R10: Status bits are sticky and cleared by writing ones with clr_we. When a set and a clear hit the same bit in the same cycle, the set wins.
- R11: A start pulse while busy_o is high is ignored. It changes neither the addresses fetched nor the direction type.
- R12: After reset busy_o, irq_o and status_o are zero and neither port has a request valid.
- R13: A request that is stalled by ready low keeps its address, write flag and data stable. The two ports are never requesting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_dir | input | 1 | Direction type latched at start: 0 read, 1 write |
| list_base | input | 32 | Address of the first descriptor |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 5 | Status bits to clear |
| busy_o | output | 1 | Walk in progress |
| irq_o | output | 1 | One-cycle done interrupt |
| status_o | output | 5 | Sticky status: 0 read done, 1 write done, 2 read error, 3 write error, 4 list error |
| d_req_valid | output | 1 | Descriptor read request valid |
| d_req_ready | input | 1 | Descriptor port accepts request |
| d_req_addr | output | 32 | Descriptor word address |
| d_rsp_valid | input | 1 | Descriptor response valid |
| d_rsp_data | input | 32 | Descriptor word |
| d_rsp_err | input | 1 | Descriptor response error |
| m_req_valid | output | 1 | Data request valid |
| m_req_ready | input | 1 | Data port accepts request |
| m_req_we | output | 1 | 1 write, 0 read |
| m_req_addr | output | 32 | Data word address |
| m_req_wdata | output | 32 | Write data |
| m_req_be | output | 4 | Byte enables, bit n for address+n |
| m_rsp_valid | input | 1 | Data response valid |
| m_rsp_rdata | input | 32 | Read data |
| m_rsp_err | input | 1 | Data response error |

## Verification
The status register can take a software clear and a hardware set in the same cycle. The bench provokes this by holding a write-one clear of the read-done bit for the whole of a read-type walk. The completion of the last descriptor therefore lands in a cycle where that clear is active. The bench samples status at the falling edge of the cycle in which irq_o is high, and expects the read-done bit to be set there. It then expects the held clear to remove the bit on the following edge.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int WORD_W      = 32;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int CNT_W       = 18;
  localparam int DESC_WORDS  = 3;
  localparam int DESC_BYTES  = DESC_WORDS * WORD_BYTES;
  localparam int LAST_BIT    = WORD_W - 1;
  localparam int ST_W        = 5;
  localparam int ST_RD_DONE  = 0;
  localparam int ST_WR_DONE  = 1;
  localparam int ST_RD_ERR   = 2;
  localparam int ST_WR_ERR   = 3;
  localparam int ST_LIST_ERR = 4;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] ctl;
  } sgd_desc_t;

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_COPY} walk_st_e;
endpackage

// File: rtl/sgd_status.sv
module sgd_status
  import sgd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_mask,
  output logic [ST_W-1:0] status
);
  logic [ST_W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  // set has priority over a clear landing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_eff) | set_vec;
  end
endmodule

// File: rtl/sgd_fetch.sv
module sgd_fetch
  import sgd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [WORD_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              done,
  output logic              fail,
  output sgd_desc_t         desc
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} f_st_e;
  localparam int IDX_W = $clog2(DESC_WORDS);

  f_st_e            st;
  logic [IDX_W-1:0] widx;

  assign req_valid = (st == F_REQ);
  assign req_addr  = base + WORD_W'(widx) * WORD_W'(WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= F_IDLE;
      widx <= '0;
      done <= 1'b0;
      fail <= 1'b0;
      desc <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          st   <= F_REQ;
          widx <= '0;
        end
        F_REQ: if (req_ready) st <= F_WAIT;
        F_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            fail <= 1'b1;
            st   <= F_IDLE;
          end else begin
            case (widx)
              IDX_W'(0): desc.src <= rsp_data;
              IDX_W'(1): desc.dst <= rsp_data;
              default:   desc.ctl <= rsp_data;
            endcase
            if (widx == IDX_W'(DESC_WORDS - 1)) begin
              done <= 1'b1;
              st   <= F_IDLE;
            end else begin
              widx <= widx + IDX_W'(1);
              st   <= F_REQ;
            end
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgd_copy.sv
module sgd_copy
  import sgd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [WORD_W-1:0]     src,
  input  logic [WORD_W-1:0]     dst,
  input  logic [CNT_W-1:0]      count,
  output logic                  m_req_valid,
  input  logic                  m_req_ready,
  output logic                  m_req_we,
  output logic [WORD_W-1:0]     m_req_addr,
  output logic [WORD_W-1:0]     m_req_wdata,
  output logic [WORD_BYTES-1:0] m_req_be,
  input  logic                  m_rsp_valid,
  input  logic [WORD_W-1:0]     m_rsp_rdata,
  input  logic                  m_rsp_err,
  output logic                  done,
  output logic                  fail
);
  typedef enum logic [2:0] {C_IDLE, C_RD, C_RWAIT, C_WR, C_WWAIT} c_st_e;

  c_st_e             st;
  logic [CNT_W-1:0]  off;
  logic [CNT_W-1:0]  remaining;
  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] off_ext;
  logic              final_word;

  assign remaining  = count - off;
  assign final_word = (remaining <= CNT_W'(WORD_BYTES));
  assign off_ext    = WORD_W'(off);

  assign m_req_valid = (st == C_RD) || (st == C_WR);
  assign m_req_we    = (st == C_WR);
  assign m_req_addr  = m_req_we ? (dst + off_ext) : (src + off_ext);
  assign m_req_wdata = hold;

  // lane n enabled while at least n+1 bytes remain (little-endian lanes)
  always_comb begin
    for (int i = 0; i < WORD_BYTES; i++)
      m_req_be[i] = (remaining > CNT_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= C_IDLE;
      off  <= '0;
      hold <= '0;
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        C_IDLE: if (go) begin
          st  <= C_RD;
          off <= '0;
        end
        C_RD: if (m_req_ready) st <= C_RWAIT;
        C_RWAIT: if (m_rsp_valid) begin
          if (m_rsp_err) begin
            fail <= 1'b1;
            st   <= C_IDLE;
          end else begin
            hold <= m_rsp_rdata;
            st   <= C_WR;
          end
        end
        C_WR: if (m_req_ready) st <= C_WWAIT;
        C_WWAIT: if (m_rsp_valid) begin
          if (m_rsp_err) begin
            fail <= 1'b1;
            st   <= C_IDLE;
          end else if (final_word) begin
            done <= 1'b1;
            st   <= C_IDLE;
          end else begin
            off <= off + CNT_W'(WORD_BYTES);
            st  <= C_RD;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sgd_pkg::*;
#(
  parameter int MAX_DESC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_dir,
  input  logic [WORD_W-1:0]     list_base,
  input  logic                  clr_we,
  input  logic [ST_W-1:0]       clr_mask,
  output logic                  busy_o,
  output logic                  irq_o,
  output logic [ST_W-1:0]       status_o,
  output logic                  d_req_valid,
  input  logic                  d_req_ready,
  output logic [WORD_W-1:0]     d_req_addr,
  input  logic                  d_rsp_valid,
  input  logic [WORD_W-1:0]     d_rsp_data,
  input  logic                  d_rsp_err,
  output logic                  m_req_valid,
  input  logic                  m_req_ready,
  output logic                  m_req_we,
  output logic [WORD_W-1:0]     m_req_addr,
  output logic [WORD_W-1:0]     m_req_wdata,
  output logic [WORD_BYTES-1:0] m_req_be,
  input  logic                  m_rsp_valid,
  input  logic [WORD_W-1:0]     m_rsp_rdata,
  input  logic                  m_rsp_err
);
  localparam int DC_W = $clog2(MAX_DESC + 1);

  walk_st_e          st;
  logic [WORD_W-1:0] ptr;
  logic              dir_q;
  logic [DC_W-1:0]   dcnt;
  logic              fetch_go, copy_go;
  logic              f_done, f_fail, c_done, c_fail;
  sgd_desc_t         desc;
  logic              desc_bad;
  logic [ST_W-1:0]   set_vec;
  logic              finish, advance, irq_ev;

  sgd_fetch u_fetch (
    .clk, .rst_n,
    .go        (fetch_go),
    .base      (ptr),
    .req_valid (d_req_valid),
    .req_ready (d_req_ready),
    .req_addr  (d_req_addr),
    .rsp_valid (d_rsp_valid),
    .rsp_data  (d_rsp_data),
    .rsp_err   (d_rsp_err),
    .done      (f_done),
    .fail      (f_fail),
    .desc      (desc)
  );

  sgd_copy u_copy (
    .clk, .rst_n,
    .go          (copy_go),
    .src         (desc.src),
    .dst         (desc.dst),
    .count       (desc.ctl[CNT_W-1:0]),
    .m_req_valid, .m_req_ready, .m_req_we, .m_req_addr,
    .m_req_wdata, .m_req_be, .m_rsp_valid, .m_rsp_rdata, .m_rsp_err,
    .done        (c_done),
    .fail        (c_fail)
  );

  sgd_status u_status (
    .clk, .rst_n,
    .set_vec  (set_vec),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .status   (status_o)
  );

  assign desc_bad = (desc.ctl[CNT_W-1:0] == '0) || (|desc.ctl[LAST_BIT-1:CNT_W]);
  assign busy_o   = (st != W_IDLE);

  always_comb begin
    set_vec = '0;
    finish  = 1'b0;
    advance = 1'b0;
    irq_ev  = 1'b0;
    case (st)
      W_FETCH: begin
        if (f_fail || (f_done && desc_bad)) begin
          set_vec[ST_LIST_ERR] = 1'b1;
          finish = 1'b1;
        end
      end
      W_COPY: begin
        if (c_fail) begin
          if (dir_q) set_vec[ST_WR_ERR] = 1'b1;
          else       set_vec[ST_RD_ERR] = 1'b1;
          finish = 1'b1;
        end else if (c_done) begin
          if (desc.ctl[LAST_BIT]) begin
            if (dir_q) set_vec[ST_WR_DONE] = 1'b1;
            else       set_vec[ST_RD_DONE] = 1'b1;
            irq_ev = 1'b1;
            finish = 1'b1;
          end else if (dcnt == DC_W'(MAX_DESC - 1)) begin
            set_vec[ST_LIST_ERR] = 1'b1;
            finish = 1'b1;
          end else begin
            advance = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      ptr      <= '0;
      dir_q    <= 1'b0;
      dcnt     <= '0;
      fetch_go <= 1'b0;
      copy_go  <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      fetch_go <= 1'b0;
      copy_go  <= 1'b0;
      irq_o    <= irq_ev;
      case (st)
        W_IDLE: if (start) begin
          st       <= W_FETCH;
          ptr      <= list_base;
          dir_q    <= start_dir;
          dcnt     <= '0;
          fetch_go <= 1'b1;
        end
        W_FETCH: begin
          if (finish) st <= W_IDLE;
          else if (f_done) begin
            st      <= W_COPY;
            copy_go <= 1'b1;
          end
        end
        W_COPY: begin
          if (finish) st <= W_IDLE;
          else if (advance) begin
            st       <= W_FETCH;
            ptr      <= ptr + WORD_W'(DESC_BYTES);
            dcnt     <= dcnt + DC_W'(1);
            fetch_go <= 1'b1;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
  import sgd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              irq_o,
  input logic [ST_W-1:0]   status_o,
  input logic              clr_we,
  input logic [ST_W-1:0]   clr_mask,
  input logic              d_req_valid,
  input logic              d_req_ready,
  input logic [WORD_W-1:0] d_req_addr,
  input logic              m_req_valid,
  input logic              m_req_ready,
  input logic              m_req_we,
  input logic [WORD_W-1:0] m_req_addr,
  input logic [WORD_W-1:0] m_req_wdata
);
  // bits that were set and not cleared must still be set one cycle later
  logic [ST_W-1:0] kept_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kept_q <= '0;
    else        kept_q <= status_o & ~(clr_we ? clr_mask : '0);
  end

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & kept_q) == kept_q));

  a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r5_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!busy_o && (|status_o[ST_WR_DONE:ST_RD_DONE])));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!m_req_valid && !d_req_valid));

  a_r13_m_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_ready) |=>
      (m_req_valid && $stable(m_req_addr) && $stable(m_req_we) && $stable(m_req_wdata)));

  a_r13_d_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req_valid && !d_req_ready) |=> (d_req_valid && $stable(d_req_addr)));

  a_r13_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_req_valid && d_req_valid));
endmodule

bind sg_dma_engine sgd_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .status_o    (status_o),
  .clr_we      (clr_we),
  .clr_mask    (clr_mask),
  .d_req_valid (d_req_valid),
  .d_req_ready (d_req_ready),
  .d_req_addr  (d_req_addr),
  .m_req_valid (m_req_valid),
  .m_req_ready (m_req_ready),
  .m_req_we    (m_req_we),
  .m_req_addr  (m_req_addr),
  .m_req_wdata (m_req_wdata)
);

// File: tb/sg_dma_engine_tb_top.sv
module sg_dma_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0, start_dir = 1'b0, clr_we = 1'b0;
  logic [31:0] list_base = '0;
  logic [4:0]  clr_mask = '0;
  logic        busy_o, irq_o;
  logic [4:0]  status_o;
  logic        d_req_valid, d_req_ready;
  logic [31:0] d_req_addr;
  logic        d_rsp_valid = 1'b0, d_rsp_err = 1'b0;
  logic [31:0] d_rsp_data = '0;
  logic        m_req_valid, m_req_ready, m_req_we;
  logic [31:0] m_req_addr, m_req_wdata;
  logic [3:0]  m_req_be;
  logic        m_rsp_valid = 1'b0, m_rsp_err = 1'b0;
  logic [31:0] m_rsp_rdata = '0;

  sg_dma_engine #(.MAX_DESC(4)) dut_i (
    .clk, .rst_n, .start, .start_dir, .list_base, .clr_we, .clr_mask,
    .busy_o, .irq_o, .status_o,
    .d_req_valid, .d_req_ready, .d_req_addr, .d_rsp_valid, .d_rsp_data, .d_rsp_err,
    .m_req_valid, .m_req_ready, .m_req_we, .m_req_addr, .m_req_wdata, .m_req_be,
    .m_rsp_valid, .m_rsp_rdata, .m_rsp_err
  );

  int vecs = 0, fails = 0, cyc = 0, irq_cnt = 0;
  logic [4:0]  st_at_irq = '0;
  logic [31:0] mem [1024];
  logic [67:0] wq [$];
  logic [31:0] dq [$];
  logic        bp_on = 1'b0, d_err_en = 1'b0, m_err_en = 1'b0;
  logic [31:0] d_err_addr = '0, m_err_addr = '0;
  logic [7:0]  bpc = '0;
  logic [67:0] wexp;
  logic [31:0] dexp;
  logic        merr;

  task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  assign d_req_ready = bp_on ? bpc[0] : 1'b1;
  assign m_req_ready = bp_on ? (bpc[1:0] != 2'b01) : 1'b1;

  // memory model and monitor: compares each accepted request with the queues
  always @(posedge clk) begin
    bpc <= bpc + 8'd1;
    d_rsp_valid <= 1'b0;
    m_rsp_valid <= 1'b0;
    if (d_req_valid && d_req_ready) begin
      d_rsp_valid <= 1'b1;
      d_rsp_data  <= mem[d_req_addr[11:2]];
      d_rsp_err   <= d_err_en && (d_req_addr == d_err_addr);
      if (dq.size() == 0) chk(1'b0, "R1 unexpected descriptor fetch", {36'd0, d_req_addr}, '0);
      else begin
        dexp = dq.pop_front();
        chk(d_req_addr == dexp, "R1 descriptor fetch address", {36'd0, d_req_addr}, {36'd0, dexp});
      end
    end
    if (m_req_valid && m_req_ready) begin
      merr = m_err_en && (m_req_addr == m_err_addr);
      m_rsp_valid <= 1'b1;
      m_rsp_err   <= merr;
      m_rsp_rdata <= mem[m_req_addr[11:2]];
      if (m_req_we) begin
        if (wq.size() == 0)
          chk(1'b0, "R3 unexpected write", {m_req_addr, m_req_wdata, m_req_be}, '0);
        else begin
          wexp = wq.pop_front();
          chk({m_req_addr, m_req_wdata, m_req_be} == wexp, "R3/R4 write addr,data,be",
              {m_req_addr, m_req_wdata, m_req_be}, wexp);
        end
        if (!merr)
          for (int b = 0; b < 4; b++)
            if (m_req_be[b]) mem[m_req_addr[11:2]][8*b +: 8] = m_req_wdata[8*b +: 8];
      end
    end
  end

  always @(negedge clk) begin
    if (irq_o) begin
      irq_cnt++;
      st_at_irq = status_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c);
    mem[a[11:2]] = s;
    mem[a[11:2] + 10'd1] = d;
    mem[a[11:2] + 10'd2] = c;
  endtask

  task automatic exp_fetch(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) dq.push_back(a + 32'(4 * i));
  endtask

  // driver side of the scoreboard: expected writes from the requirement
  task automatic exp_copy(input logic [31:0] s, input logic [31:0] d, input int n, input int lim);
    for (int k = 0; k < (n + 3) / 4 && k < lim; k++) begin
      int rem = n - 4 * k;
      logic [3:0] be = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
      wq.push_back({d + 32'(4 * k), mem[s[11:2] + 10'(k)], be});
    end
  endtask

  task automatic run(input logic [31:0] base, input logic dir, input bit poke);
    int n = 0;
    irq_cnt = 0;
    @(negedge clk);
    start = 1'b1; list_base = base; start_dir = dir;
    @(negedge clk);
    start = 1'b0;
    while (busy_o && n < 5000) begin
      @(negedge clk);
      n++;
      if (poke && n == 4) begin
        start = 1'b1; list_base = 32'h0; start_dir = ~dir;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk(!busy_o, "R5 walk finished", {67'd0, busy_o}, '0);
    @(negedge clk);
  endtask

  task automatic clear(input logic [4:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic end_checks(input string tag, input logic [4:0] st, input int irqs);
    chk(status_o == st, {tag, " status"}, {63'd0, status_o}, {63'd0, st});
    chk(irq_cnt == irqs, {tag, " irq count"}, 68'(irq_cnt), 68'(irqs));
    chk(wq.size() == 0, {tag, " writes left"}, 68'(wq.size()), '0);
    chk(dq.size() == 0, {tag, " fetches left"}, 68'(dq.size()), '0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h1357_9BDF ^ (32'(i) * 32'h0103_0507);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy_o && !irq_o && status_o == 0 && !m_req_valid && !d_req_valid,
        "R12 reset state", {62'd0, busy_o, irq_o, status_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R5: one read-type descriptor with last flag
    put_desc(32'h000, 32'h400, 32'h800, 32'h8000_0010);
    exp_fetch(32'h000, 3); exp_copy(32'h400, 32'h800, 16, 99);
    run(32'h000, 1'b0, 0);
    end_checks("R5 single read", 5'b00001, 1);
    clear(5'h1F);
    chk(status_o == 0, "R10 clear all", {63'd0, status_o}, '0);

    // R2 R4: chained write-type walk with tails, under back-pressure
    bp_on = 1'b1;
    put_desc(32'h040, 32'h410, 32'h840, 32'd7);
    put_desc(32'h04C, 32'h420, 32'h860, 32'd4);
    put_desc(32'h058, 32'h430, 32'h880, 32'h8000_000D);
    exp_fetch(32'h040, 3); exp_copy(32'h410, 32'h840, 7, 99);
    exp_fetch(32'h04C, 3); exp_copy(32'h420, 32'h860, 4, 99);
    exp_fetch(32'h058, 3); exp_copy(32'h430, 32'h880, 13, 99);
    run(32'h040, 1'b1, 0);
    end_checks("R4 chain write", 5'b00010, 1);
    clear(5'b00001);
    chk(status_o == 5'b00010, "R10 partial clear keeps bit1", {63'd0, status_o}, 68'h2);
    clear(5'b00010);
    chk(status_o == 0, "R10 clear bit1", {63'd0, status_o}, '0);
    bp_on = 1'b0;

    // R6: zero count, then reserved bit set
    put_desc(32'h100, 32'h400, 32'h900, 32'h8000_0000);
    exp_fetch(32'h100, 3);
    run(32'h100, 1'b0, 0);
    end_checks("R6 zero count", 5'b10000, 0);
    clear(5'h1F);
    put_desc(32'h110, 32'h400, 32'h900, 32'h8010_0008);
    exp_fetch(32'h110, 3);
    run(32'h110, 1'b0, 0);
    end_checks("R2 R6 reserved bit", 5'b10000, 0);
    clear(5'h1F);

    // R7: MAX_DESC=4 descriptors with no last flag
    for (int i = 0; i < 4; i++) begin
      put_desc(32'h140 + 32'(12 * i), 32'h440 + 32'(4 * i), 32'h8C0 + 32'(4 * i), 32'd4);
      exp_fetch(32'h140 + 32'(12 * i), 3);
      exp_copy(32'h440 + 32'(4 * i), 32'h8C0 + 32'(4 * i), 4, 99);
    end
    put_desc(32'h170, 32'h450, 32'h8E0, 32'h8000_0004);
    run(32'h140, 1'b0, 0);
    end_checks("R7 bound", 5'b10000, 0);
    clear(5'h1F);

    // R8: read error on a read-type walk, write error on a write-type walk
    put_desc(32'h180, 32'h480, 32'h900, 32'h8000_000C);
    exp_fetch(32'h180, 3); exp_copy(32'h480, 32'h900, 12, 1);
    m_err_en = 1'b1; m_err_addr = 32'h484;
    run(32'h180, 1'b0, 0);
    end_checks("R8 read error", 5'b00100, 0);
    clear(5'h1F);
    put_desc(32'h190, 32'h490, 32'h940, 32'h8000_0008);
    exp_fetch(32'h190, 3); exp_copy(32'h490, 32'h940, 8, 1);
    m_err_addr = 32'h940;
    run(32'h190, 1'b1, 0);
    end_checks("R8 write error", 5'b01000, 0);
    m_err_en = 1'b0;
    clear(5'h1F);

    // R9: descriptor port error on the second word
    put_desc(32'h1A0, 32'h4A0, 32'h980, 32'h8000_0008);
    exp_fetch(32'h1A0, 2);
    d_err_en = 1'b1; d_err_addr = 32'h1A4;
    run(32'h1A0, 1'b0, 0);
    end_checks("R9 descriptor error", 5'b10000, 0);
    d_err_en = 1'b0;
    clear(5'h1F);

    // R11: start while busy, other base and other direction
    put_desc(32'h1C0, 32'h4A0, 32'h980, 32'h8000_0020);
    exp_fetch(32'h1C0, 3); exp_copy(32'h4A0, 32'h980, 32, 99);
    run(32'h1C0, 1'b0, 1);
    end_checks("R11 start while busy", 5'b00001, 1);
    clear(5'h1F);

    // R10: completion set and held clear of the same bit in the same cycle
    put_desc(32'h1D0, 32'h4C0, 32'h9C0, 32'h8000_0008);
    exp_fetch(32'h1D0, 3); exp_copy(32'h4C0, 32'h9C0, 8, 99);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = 5'b00001;
    run(32'h1D0, 1'b0, 0);
    chk(st_at_irq[0] == 1'b1, "R10 set wins over clear", {63'd0, st_at_irq}, 68'h1);
    chk(status_o == 0, "R10 held clear after set", {63'd0, status_o}, '0);
    chk(irq_cnt == 1, "R5 irq during collision", 68'(irq_cnt), 68'h1);
    clr_we = 1'b0; clr_mask = '0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule